// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Masks

This block watches a real-time clock's BCD seconds, minutes, hours and day-of-month. Once each second, on the clock's update strobe, it compares them with four programmed alarm bytes. Bit 7 of each alarm byte is a repeat bit. Together the four repeat bits choose which of the four fields must match, which gives an alarm every second, minute, hour, day or month. When the selected fields agree, a sticky alarm flag is set. The flag drives an active-low interrupt request if interrupts are enabled.

Software loads the alarm bytes and an interrupt-enable byte through a simple byte-write port. It acknowledges an alarm with a flags-read strobe, which clears the flag. A backup-mode input marks periods when the main supply is absent. In that state the interrupt is allowed only when a second enable, reserved for backup operation, is also set. Reset stands for power-up: it clears the flag, the enables and the alarm bytes.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: Reset clears the alarm flag, the alarm bytes and both enables: alarm_flag reads 0 and irq_n reads 1. Because the enables are clear after reset, a match after reset sets the flag but leaves irq_n high.
- R2: Write select codes are 0 for the seconds alarm, 1 for minutes, 2 for hours, 3 for date and 4 for the enable byte. Bit 7 of each alarm byte is its repeat bit. The repeat code {date[7], hour[7], min[7], sec[7]} = 1111 sets the flag on every strobe.
- R3: Code 1110 sets the flag only when the seconds field (bits 6:0) equals the current seconds.
- R4: Code 1100 requires seconds and minutes to match.
- R5: Code 1000 requires seconds, minutes and hours to match.
- R6: Code 0000 requires all four fields, including the date, to match.
- R7: Any other repeat code behaves like 1111 and fires every strobe.
- R8: The flag is set only by a strobe cycle with a match, and it becomes visible in the cycle after the strobe. Without a strobe, matching time values have no effect.
- R9: In normal mode, irq_n is low exactly while the flag is set and the interrupt enable (enable byte bit 0) is 1.
- R10: While backup is high, irq_n goes low only if the flag, the interrupt enable and the backup enable (enable byte bit 1) are all set.
- R11: A flags-read strobe clears the flag and releases irq_n in the next cycle. If a read and a matching strobe coincide, the flag stays set.
- R12: When the whole date alarm byte and all four repeat bits are zero, the alarm is disabled and never fires. This holds even when the current date is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| tick | input | 1 | Once-per-second strobe; the time inputs are current |
| cur_sec | input | 7 | Current BCD seconds |
| cur_min | input | 7 | Current BCD minutes |
| cur_hour | input | 7 | Current BCD hours |
| cur_date | input | 7 | Current BCD day of month |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 sec, 1 min, 2 hour, 3 date, 4 enables) |
| wr_data | input | 8 | Write data |
| flag_rd | input | 1 | Flags-register read strobe |
| backup | input | 1 | High while on backup power |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets a read strobe that arrives in the same cycle as a matching strobe. A design that gives the read priority would lose that alarm, and the flag would read 0. It programs the all-zero disable pattern and presents a current date of 00. A comparator without the explicit disable would then fire in month mode. It writes undefined repeat codes, and a decoder that treated them as a wider mask would stay silent. It also holds matching time values without a strobe, and toggles backup with only one of the two enables set. These cases expose an alarm taken outside the strobe and an interrupt that ignores the backup gate.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   localparam int unsigned NFIELD = 4;
   localparam int unsigned SEL_W  = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_SEC  = 3'd0,
      SEL_MIN  = 3'd1,
      SEL_HOUR = 3'd2,
      SEL_DATE = 3'd3,
      SEL_ENA  = 3'd4
   } reg_sel_e;

   // repeat code bit i comes from bit 7 of alarm field i (0 sec .. 3 date)
   typedef enum logic [NFIELD-1:0] {
      RPT_EVERY_SEC  = 4'b1111,
      RPT_EVERY_MIN  = 4'b1110,
      RPT_EVERY_HOUR = 4'b1100,
      RPT_EVERY_DAY  = 4'b1000,
      RPT_EVERY_MON  = 4'b0000
   } rpt_code_e;

   // fields that must agree for a given repeat code; bit i = field i
   function automatic logic [NFIELD-1:0] field_mask(input logic [NFIELD-1:0] code);
      logic [NFIELD-1:0] m;
      case (code)
         RPT_EVERY_MIN:  m = 4'b0001;
         RPT_EVERY_HOUR: m = 4'b0011;
         RPT_EVERY_DAY:  m = 4'b0111;
         RPT_EVERY_MON:  m = 4'b1111;
         default:        m = 4'b0000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter int unsigned IRQ_BIT = 0,
   parameter int unsigned BKP_BIT = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic [DW-1:0]        wr_data,
   output logic [NFIELD*DW-1:0] alm_flat,
   output logic                 irq_en,
   output logic                 bkp_en
);

   generate
      if (IRQ_BIT >= DW || BKP_BIT >= DW || IRQ_BIT == BKP_BIT) begin : g_bad_bits
         $error("rtc_alarm_regs: enable bit positions invalid");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NFIELD; gi++) begin : g_field
         logic [DW-1:0] byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               byte_q <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(gi))) begin
               byte_q <= wr_data;
            end
         end
         assign alm_flat[gi*DW +: DW] = byte_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en <= 1'b0;
         bkp_en <= 1'b0;
      end else if (wr_en && (wr_sel == SEL_ENA)) begin
         irq_en <= wr_data[IRQ_BIT];
         bkp_en <= wr_data[BKP_BIT];
      end
   end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned DW = 8,
   localparam int unsigned TW = DW - 1
) (
   input  logic [NFIELD*DW-1:0] alm_flat,
   input  logic [NFIELD*TW-1:0] cur_flat,
   output logic                 hit
);

   logic [NFIELD-1:0] rpt_code;
   logic [NFIELD-1:0] field_eq;
   logic [NFIELD-1:0] need;
   logic              disabled;

   genvar gi;
   generate
      for (gi = 0; gi < NFIELD; gi++) begin : g_cmp
         assign rpt_code[gi] = alm_flat[gi*DW + TW];
         assign field_eq[gi] = (alm_flat[gi*DW +: TW] == cur_flat[gi*TW +: TW]);
      end
   endgenerate

   assign need     = field_mask(rpt_code);
   assign disabled = (alm_flat[(NFIELD-1)*DW +: DW] == '0) && (rpt_code == '0);
   assign hit      = !disabled && (&(field_eq | ~need));

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hit,
   input  logic flag_rd,
   input  logic irq_en,
   input  logic bkp_en,
   input  logic backup,
   output logic alarm_flag,
   output logic irq_n
);

   logic flag_q;
   logic irq_req;

   // a fresh match outranks a clearing read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (tick && hit) begin
         flag_q <= 1'b1;
      end else if (flag_rd) begin
         flag_q <= 1'b0;
      end
   end

   assign alarm_flag = flag_q;
   assign irq_req    = flag_q && irq_en && (!backup || bkp_en);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= irq_req;
            end
         end
         assign irq_n = !irq_q;
      end else begin : g_irq_comb
         assign irq_n = !irq_req;
      end
   endgenerate

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter bit          IRQ_REG = 1'b0,
   localparam int unsigned TW     = DW - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [TW-1:0]    cur_sec,
   input  logic [TW-1:0]    cur_min,
   input  logic [TW-1:0]    cur_hour,
   input  logic [TW-1:0]    cur_date,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [DW-1:0]    wr_data,
   input  logic             flag_rd,
   input  logic             backup,
   output logic             alarm_flag,
   output logic             irq_n
);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("rtc_alarm_cmp: DW must hold a BCD field plus a repeat bit");
      end
   endgenerate

   logic [NFIELD*DW-1:0] alm_flat;
   logic [NFIELD*TW-1:0] cur_flat;
   logic                 irq_en;
   logic                 bkp_en;
   logic                 hit;

   assign cur_flat = {cur_date, cur_hour, cur_min, cur_sec};

   rtc_alarm_regs #(.DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .alm_flat (alm_flat),
      .irq_en   (irq_en),
      .bkp_en   (bkp_en)
   );

   rtc_alarm_match #(.DW(DW)) u_match (
      .alm_flat (alm_flat),
      .cur_flat (cur_flat),
      .hit      (hit)
   );

   rtc_alarm_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .hit        (hit),
      .flag_rd    (flag_rd),
      .irq_en     (irq_en),
      .bkp_en     (bkp_en),
      .backup     (backup),
      .alarm_flag (alarm_flag),
      .irq_n      (irq_n)
   );

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic flag_rd,
   input logic backup,
   input logic alarm_flag,
   input logic irq_n,
   input logic en_irq,
   input logic en_bkp
);

   // R8
   flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !$rose(alarm_flag));

   // R11
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd && !tick) |=> !alarm_flag);

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !flag_rd) |=> alarm_flag);

   // R9
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (alarm_flag && en_irq));

   // R10
   backup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && backup) |-> en_bkp);

endmodule

bind rtc_alarm_cmp rtc_alarm_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .flag_rd    (flag_rd),
   .backup     (backup),
   .alarm_flag (alarm_flag),
   .irq_n      (irq_n),
   .en_irq     (irq_en),
   .en_bkp     (bkp_en)
);

// File: tb/rtc_alarm_cmp_test.sv
`timescale 1ns/1ps
module rtc_alarm_cmp_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic [6:0] cur_sec, cur_min, cur_hour, cur_date;
   logic       wr_en;
   logic [2:0] wr_sel;
   logic [7:0] wr_data;
   logic       flag_rd;
   logic       backup;
   logic       alarm_flag;
   logic       irq_n;

   always #2 clk = ~clk;

   rtc_alarm_cmp uut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .flag_rd(flag_rd), .backup(backup),
      .alarm_flag(alarm_flag), .irq_n(irq_n)
   );

   int checks = 0;
   int errors = 0;

   logic [7:0] m_alm [4];
   logic       m_irq_en, m_bkp_en, m_flag;

   function automatic logic [3:0] exp_mask(input logic [3:0] c);
      case (c)
         4'b1110: return 4'b0001;
         4'b1100: return 4'b0011;
         4'b1000: return 4'b0111;
         4'b0000: return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic exp_hit(input logic [6:0] s, input logic [6:0] mi,
                                    input logic [6:0] h, input logic [6:0] d);
      logic [3:0] code;
      logic [3:0] mk;
      logic [6:0] cur [4];
      code = {m_alm[3][7], m_alm[2][7], m_alm[1][7], m_alm[0][7]};
      if (m_alm[3] == 8'h00 && code == 4'b0000) return 1'b0;
      mk = exp_mask(code);
      cur[0] = s; cur[1] = mi; cur[2] = h; cur[3] = d;
      for (int i = 0; i < 4; i++) begin
         if (mk[i] && cur[i] != m_alm[i][6:0]) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic logic exp_irq_n();
      return !(m_flag && m_irq_en && (!backup || m_bkp_en));
   endfunction

   function automatic string mode_req(input logic [3:0] c);
      case (c)
         4'b1111: return "R2";
         4'b1110: return "R3";
         4'b1100: return "R4";
         4'b1000: return "R5";
         4'b0000: return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [6:0] rbcd(input int lo, input int hi);
      int v;
      v = $urandom_range(hi, lo);
      return {3'(v / 10), 4'(v % 10)};
   endfunction

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (sel < 3'd4) m_alm[sel] = d;
      else if (sel == 3'd4) begin
         m_irq_en = d[0];
         m_bkp_en = d[1];
      end
   endtask

   task automatic step(input logic [6:0] s, input logic [6:0] mi, input logic [6:0] h,
                       input logic [6:0] d, input logic tk, input logic rd, input string req);
      logic h_exp;
      @(negedge clk);
      cur_sec = s; cur_min = mi; cur_hour = h; cur_date = d;
      tick = tk; flag_rd = rd;
      h_exp = tk && exp_hit(s, mi, h, d);
      @(negedge clk);
      tick = 1'b0; flag_rd = 1'b0;
      if (h_exp) m_flag = 1'b1;
      else if (rd) m_flag = 1'b0;
      chk(req, alarm_flag, m_flag, "alarm_flag");
      chk(req, irq_n, exp_irq_n(), "irq_n");
   endtask

   task automatic set_alarm(input logic [7:0] s, input logic [7:0] mi,
                            input logic [7:0] h, input logic [7:0] d);
      wreg(3'd0, s); wreg(3'd1, mi); wreg(3'd2, h); wreg(3'd3, d);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [3:0] codes [5];
      void'($urandom(32'd20240611));
      codes[0] = 4'b1111; codes[1] = 4'b1110; codes[2] = 4'b1100;
      codes[3] = 4'b1000; codes[4] = 4'b0000;
      rst_n = 1'b0; tick = 1'b0; flag_rd = 1'b0; backup = 1'b0;
      wr_en = 1'b0; wr_sel = '0; wr_data = '0;
      cur_sec = '0; cur_min = '0; cur_hour = '0; cur_date = '0;
      for (int i = 0; i < 4; i++) m_alm[i] = 8'h00;
      m_irq_en = 1'b0; m_bkp_en = 1'b0; m_flag = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", alarm_flag, 1'b0, "reset flag");
      chk("R1", irq_n, 1'b1, "reset irq_n");

      // all-zero registers: disabled even with date 00
      step(7'h00, 7'h00, 7'h00, 7'h00, 1'b1, 1'b0, "R12");

      // every-second mode with enables still cleared from reset
      set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
      step(7'h12, 7'h34, 7'h05, 7'h17, 1'b1, 1'b0, "R1");
      chk("R1", irq_n, 1'b1, "irq held off after reset");

      wreg(3'd4, 8'h01);
      chk("R9", irq_n, 1'b0, "irq after enable");

      // read clears
      step(7'h13, 7'h34, 7'h05, 7'h17, 1'b0, 1'b1, "R11");
      chk("R11", alarm_flag, 1'b0, "flag after read");
      // no strobe, no flag
      step(7'h13, 7'h34, 7'h05, 7'h17, 1'b0, 1'b0, "R8");
      chk("R8", alarm_flag, 1'b0, "flag without strobe");
      step(7'h14, 7'h34, 7'h05, 7'h17, 1'b1, 1'b0, "R2");
      // read and match together: match wins
      step(7'h15, 7'h34, 7'h05, 7'h17, 1'b1, 1'b1, "R11");
      chk("R11", alarm_flag, 1'b1, "match beats read");
      step(7'h15, 7'h34, 7'h05, 7'h17, 1'b0, 1'b1, "R11");

      // backup gating
      backup = 1'b1;
      step(7'h16, 7'h34, 7'h05, 7'h17, 1'b1, 1'b0, "R10");
      chk("R10", irq_n, 1'b1, "backup without backup enable");
      wreg(3'd4, 8'h03);
      chk("R10", irq_n, 1'b0, "backup with both enables");
      wreg(3'd4, 8'h02);
      chk("R10", irq_n, 1'b1, "backup enable alone");
      backup = 1'b0;
      wreg(3'd4, 8'h01);
      step(7'h16, 7'h34, 7'h05, 7'h17, 1'b0, 1'b1, "R11");

      // seconds-only mode
      set_alarm(8'h30, 8'h80, 8'h80, 8'h80);
      step(7'h29, 7'h10, 7'h01, 7'h02, 1'b1, 1'b0, "R3");
      chk("R3", alarm_flag, 1'b0, "seconds mismatch");
      step(7'h30, 7'h44, 7'h21, 7'h30, 1'b1, 1'b0, "R3");
      chk("R3", alarm_flag, 1'b1, "seconds match");
      step(7'h30, 7'h44, 7'h21, 7'h30, 1'b0, 1'b1, "R11");

      // month mode, only the date differs
      set_alarm(8'h00, 8'h30, 8'h08, 8'h15);
      step(7'h00, 7'h30, 7'h08, 7'h14, 1'b1, 1'b0, "R6");
      chk("R6", alarm_flag, 1'b0, "date mismatch");
      step(7'h00, 7'h30, 7'h08, 7'h15, 1'b1, 1'b0, "R6");
      chk("R6", alarm_flag, 1'b1, "full match");
      step(7'h00, 7'h30, 7'h08, 7'h15, 1'b0, 1'b1, "R11");

      // undefined code 0101 fires anyway
      set_alarm(8'h80 | 8'h11, 8'h22, 8'h80 | 8'h03, 8'h00);
      step(7'h59, 7'h58, 7'h23, 7'h31, 1'b1, 1'b0, "R7");
      chk("R7", alarm_flag, 1'b1, "undefined code");
      step(7'h59, 7'h58, 7'h23, 7'h31, 1'b0, 1'b1, "R11");

      // explicit disable pattern again, date 00 presented
      set_alarm(8'h00, 8'h00, 8'h00, 8'h00);
      step(7'h00, 7'h00, 7'h00, 7'h00, 1'b1, 1'b0, "R12");
      chk("R12", alarm_flag, 1'b0, "disabled alarm");

      // constrained random
      for (int it = 0; it < 600; it++) begin
         logic [3:0] code;
         logic [6:0] s, mi, h, d;
         logic       rd;
         if (it % 8 == 0) begin
            if ($urandom_range(5, 0) == 5) begin
               do code = 4'($urandom_range(15, 0));
               while (code inside {4'b1111, 4'b1110, 4'b1100, 4'b1000, 4'b0000});
            end else begin
               code = codes[$urandom_range(4, 0)];
            end
            set_alarm({code[0], rbcd(0, 59)}, {code[1], rbcd(0, 59)},
                      {code[2], rbcd(0, 23)}, {code[3], rbcd(1, 31)});
            wreg(3'd4, 8'($urandom_range(3, 0)));
            backup = 1'($urandom_range(1, 0));
         end
         code = {m_alm[3][7], m_alm[2][7], m_alm[1][7], m_alm[0][7]};
         if ($urandom_range(9, 0) < 6) begin
            s = m_alm[0][6:0]; mi = m_alm[1][6:0]; h = m_alm[2][6:0]; d = m_alm[3][6:0];
            case ($urandom_range(4, 0))
               0: s  = rbcd(0, 59);
               1: mi = rbcd(0, 59);
               2: h  = rbcd(0, 23);
               3: d  = rbcd(1, 31);
               default: ;
            endcase
         end else begin
            s = rbcd(0, 59); mi = rbcd(0, 59); h = rbcd(0, 23); d = rbcd(1, 31);
         end
         rd = ($urandom_range(3, 0) == 0);
         step(s, mi, h, d, 1'($urandom_range(7, 0) != 0), rd, mode_req(code));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule